// File: doc/BRIEF.md
# Two-Bit Four-Function ALU

This block is a combinational arithmetic and logic slice for two small operands. A two-bit operation code picks one of four functions. They are the bitwise AND of the operands, their binary sum, the inverse of the first operand, and a one-place left shift of the first operand. The block drives a result of operand width and a single carry bit. The carry bit holds the adder's overflow for the sum and the bit pushed out for the shift.

There is no clock, register or reset inside. The outputs follow the inputs after the gate delay alone, so a surrounding pipeline can place the slice between its own registers. The operand width is a parameter that defaults to two bits. The operation set and the encoding do not change with the width.

Top module: `duo_alu`

## Requirements
- R1: With op_sel = 2'b00 the result equals opd_a AND opd_b bit by bit, and carry_out is 0.
- R2: With op_sel = 2'b01 the concatenation {carry_out, result} equals the unsigned sum opd_a + opd_b, so carry_out is the carry leaving the most significant bit.
- R3: With op_sel = 2'b10 the result is the bitwise inverse of opd_a and carry_out is 0. opd_b has no effect on either output.
- R4: With op_sel = 2'b11 the result is opd_a shifted left by one place with 0 entering bit 0, and carry_out is the old most significant bit of opd_a. opd_b has no effect on either output.
- R5: The outputs depend only on opd_a, opd_b and op_sel. A change at these inputs appears at the outputs without any clock edge. With all inputs at zero, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | WIDTH | First operand; the only source for inverse and shift |
| opd_b | input | WIDTH | Second operand, used by AND and sum |
| op_sel | input | 2 | Operation code: 00 AND, 01 sum, 10 inverse of A, 11 shift left of A |
| result | output | WIDTH | Result of the selected operation |
| carry_out | output | 1 | Sum overflow, shifted-out bit, or 0 |

## Verification
The block holds no state. A fault in its internal nets shows at the ports in the same evaluation as the inputs that expose it, and it is gone as soon as those inputs change. A broken link in the ripple carry chain shows only for operand pairs whose carry passes through that link, so the bench applies every operand pair under every code. A select decode that routes the wrong unit, or that lets opd_b leak into the inverse or shift paths, changes the result for some pair in that sweep. Each pair is sampled between clock edges, and one further check changes an operand with no edge in between to confirm that nothing is registered.

// File: rtl/duo_alu_pkg.sv
package duo_alu_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        OP_AND = 2'b00,
        OP_ADD = 2'b01,
        OP_INV = 2'b10,
        OP_SHL = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic cout;
        logic sum;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic x, input logic y, input logic cin);
        fa_out_t r;
        r.sum  = x ^ y ^ cin;
        r.cout = (x & y) | (cin & (x ^ y));
        return r;
    endfunction

endpackage

// File: rtl/duo_alu_adder.sv
module duo_alu_adder
    import duo_alu_pkg::*;
#(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] chain;
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        fa_out_t fa;
        assign fa         = full_add(x[i], y[i], chain[i]);
        assign sum[i]     = fa.sum;
        assign chain[i+1] = fa.cout;
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/duo_alu_logic.sv
module duo_alu_logic #(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] and_out,
    output logic [WIDTH-1:0] inv_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign and_out[i] = x[i] & y[i];
        assign inv_out[i] = ~x[i];
    end
endmodule

// File: rtl/duo_alu_shift.sv
module duo_alu_shift #(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] shl_out,
    output logic             shl_cout
);
    assign shl_out[0] = 1'b0;
    for (genvar i = 1; i < WIDTH; i++) begin : g_bit
        assign shl_out[i] = x[i-1];
    end
    assign shl_cout = x[WIDTH-1];
endmodule

// File: rtl/duo_alu.sv
module duo_alu
    import duo_alu_pkg::*;
#(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] opd_a,
    input  logic [WIDTH-1:0] opd_b,
    input  logic [SEL_W-1:0] op_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic [WIDTH-1:0] and_val;
    logic [WIDTH-1:0] inv_val;
    logic [WIDTH-1:0] shl_val;
    logic             shl_cout;
    alu_op_e          op;

    assign op = alu_op_e'(op_sel);

    duo_alu_adder #(.WIDTH(WIDTH)) u_add (
        .x    (opd_a),
        .y    (opd_b),
        .sum  (add_sum),
        .cout (add_cout)
    );

    duo_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .x       (opd_a),
        .y       (opd_b),
        .and_out (and_val),
        .inv_out (inv_val)
    );

    duo_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .x        (opd_a),
        .shl_out  (shl_val),
        .shl_cout (shl_cout)
    );

    always_comb begin
        result    = '0;
        carry_out = 1'b0;
        unique case (op)
            OP_AND: result = and_val;
            OP_ADD: begin
                result    = add_sum;
                carry_out = add_cout;
            end
            OP_INV: result = inv_val;
            OP_SHL: begin
                result    = shl_val;
                carry_out = shl_cout;
            end
            default: begin
                result    = '0;
                carry_out = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/duo_alu_chk.sv
module duo_alu_chk #(
    parameter int WIDTH = 2
) (
    input logic [WIDTH-1:0] opd_a,
    input logic [WIDTH-1:0] opd_b,
    input logic [1:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);
    logic [WIDTH:0] wide_sum;
    logic           known;

    assign wide_sum = {1'b0, opd_a} + {1'b0, opd_b};
    assign known    = !$isunknown({opd_a, opd_b, op_sel, result, carry_out});

    always_comb begin
        if (known) begin
            if (op_sel == 2'b00) begin
                p_and_in_both_r1: assert (((result & ~opd_a) | (result & ~opd_b)) == '0
                                          && (result | ~(opd_a & opd_b)) == '1 && !carry_out);
            end
            if (op_sel == 2'b01) begin
                p_sum_carry_r2: assert ({carry_out, result} == wide_sum);
            end
            if (op_sel == 2'b10) begin
                p_inverse_r3: assert ((result ^ opd_a) == '1 && !carry_out);
            end
            if (op_sel == 2'b11) begin
                p_shift_r4: assert (!result[0] && {carry_out, result} == ({opd_a, 1'b0}));
            end
            if (opd_a == '0 && opd_b == '0) begin
                p_zero_in_r5: assert (carry_out == 1'b0 && (result == '0 || op_sel == 2'b10));
            end
        end
    end
endmodule

bind duo_alu duo_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opd_a     (opd_a),
    .opd_b     (opd_b),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/duo_alu_tb.sv
module duo_alu_tb;
    localparam int WIDTH = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIDTH-1:0] opd_a = '0;
    logic [WIDTH-1:0] opd_b = '0;
    logic [1:0]       op_sel = 2'b00;
    logic [WIDTH-1:0] result;
    logic             carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    duo_alu #(.WIDTH(WIDTH)) u_dut (
        .opd_a     (opd_a),
        .opd_b     (opd_b),
        .op_sel    (op_sel),
        .result    (result),
        .carry_out (carry_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (a=%0d b=%0d sel=%0d)",
                     req, what, act, exp, opd_a, opd_b, op_sel);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5: all-zero inputs give zero outputs
        chk("R5", "result at zero", int'(result), 0);
        chk("R5", "carry at zero", int'(carry_out), 0);

        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    int exp_r;
                    int exp_c;
                    string req;
                    @(posedge clk);
                    opd_a  = a[WIDTH-1:0];
                    opd_b  = b[WIDTH-1:0];
                    op_sel = s[1:0];
                    exp_r = 0;
                    exp_c = 0;
                    case (s)
                        0: begin
                            req = "R1";
                            for (int k = 0; k < WIDTH; k++)
                                if (((a >> k) % 2 == 1) && ((b >> k) % 2 == 1))
                                    exp_r += (1 << k);
                        end
                        1: begin
                            req = "R2";
                            exp_r = (a + b) % 4;
                            exp_c = (a + b) / 4;
                        end
                        2: begin
                            req = "R3";
                            exp_r = 3 - a;
                        end
                        default: begin
                            req = "R4";
                            exp_r = (a * 2) % 4;
                            exp_c = a / 2;
                        end
                    endcase
                    @(negedge clk);
                    chk(req, "result", int'(result), exp_r);
                    chk(req, "carry", int'(carry_out), exp_c);
                end
            end
        end

        // R5: outputs follow an input change with no clock edge between
        @(negedge clk);
        op_sel = 2'b01; opd_a = 2'd1; opd_b = 2'd2;
        #1;
        chk("R5", "sum no edge", int'(result), 3);
        chk("R5", "carry no edge", int'(carry_out), 0);
        opd_a = 2'd3;
        #1;
        chk("R5", "sum after change", int'(result), 1);
        chk("R5", "carry after change", int'(carry_out), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule